// File: doc/BRIEF.md
# Vertical Blanking and Field Generator

This block sits behind the sync slicers of a video input path. It takes a one-cycle strobe at the start of each horizontal line and a level that is high during vertical sync, both already in the system clock domain. It qualifies each vertical sync pulse by its width in lines and by its rise-to-rise period in clocks. From the qualified pulses it measures the number of lines per frame, and it places a vertical blanking window around the sync position that the previous measurement predicts.

Blanking starts a programmable number of lines (the front count) before the expected next sync. It ends a second programmable number of lines (the back count) after the sync has started. A field flag is taken from where, inside the current line, a chosen edge of vertical sync falls. A small register port carries the two line counts, an enable, the field-edge choice, the measured count and an update flag.

Top module: `vblank_field_gen`

## Requirements
- R1: After reset, register 0 reads 0x00, register 1 reads 0x04, register 2 reads 0x10, registers 3 and 4 read 0x00, and both `vblank_o` and `field_o` are low.
- R2: While register 0 bit 0 (enable) is 0, `vblank_o` is low in every cycle.
- R3: Until a first vertical sync pulse has been accepted, `vblank_o` is low even when enabled.
- R4: A vertical sync pulse is accepted at its falling edge only if the number of line strobes seen while `vs_i` was high, not counting its rising cycle, is 2 to 7, and the clocks from the previous rising edge to its rising edge are within `PER_MIN`..`PER_MAX`. A pulse that fails either test leaves the measured count unchanged.
- R5: On acceptance, the measured count becomes the number of line strobes between the previous rising edge of `vs_i` and this pulse's rising edge. It reads as bits 7:0 at register 3 and bits 11:8 at register 4 bits 3:0.
- R6: Register 4 bit 7 is set when a pulse is accepted. A cycle with `reg_rd_i` high at address 4 clears it from the next cycle on.
- R7: With enable set and a pulse accepted, let N be the line strobes since the last rise of `vs_i`, M the measured count, F the front count (register 1 bits 3:0) and B the back count (register 2). `vblank_o` is high exactly when N >= M-F, or when N < B. The start is 0 when F > M. The output follows N one cycle after the strobe or edge that changed it.
- R8: Register 0 bit 1 picks the edge that updates `field_o`: 1 for the rising edge of `vs_i`, 0 for the falling edge. The new value is 1 if the edge comes more than half of the last line period (in clocks) after the last line strobe, and 0 otherwise. It is visible from the next cycle.
- R9: Register writes store only the defined bits: register 0 bits 1:0, register 1 bits 3:0 and register 2 bits 7:0. Undefined bits read 0, writes to registers 3 and 4 have no effect, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_i | input | 1 | One-cycle strobe at each line start |
| vs_i | input | 1 | Vertical sync level, active high |
| reg_we_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears the update flag at address 4) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| vblank_o | output | 1 | Vertical blanking window |
| field_o | output | 1 | Odd/even field flag |

## Verification
The checks assume that `hs_i` is never high in the same cycle as a rising edge of `vs_i`. They also assume that the selected vertical edge never coincides with a line strobe, because the phase test relies on the count since the previous strobe. The stimulus always places each vertical edge one to fourteen clocks into a sixteen-clock line, and it keeps `vs_i` low while registers are written or read. Frames are swept over several lengths, pulse widths, edge offsets and count settings, including lengths whose period falls outside the accepted window.

// File: rtl/vfg_pkg.sv
package vfg_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] A_FRONT  = 3'd1;
  localparam logic [REG_AW-1:0] A_BACK   = 3'd2;
  localparam logic [REG_AW-1:0] A_LPF_LO = 3'd3;
  localparam logic [REG_AW-1:0] A_LPF_HI = 3'd4;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_RISE_BIT = 1;
  localparam int HI_UPD_BIT    = 7;
endpackage

// File: rtl/vfg_regs.sv
module vfg_regs
  import vfg_pkg::*;
#(
  parameter int LINE_W = 12,
  parameter int FP_W   = 4,
  parameter int BP_W   = 8,
  parameter int FP_RST = 4,
  parameter int BP_RST = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic [LINE_W-1:0] lpf_i,
  input  logic              upd_set_i,
  output logic              en_o,
  output logic              rise_mode_o,
  output logic [FP_W-1:0]   fp_o,
  output logic [BP_W-1:0]   bp_o,
  output logic              upd_o
);
  localparam int HI_W = LINE_W - 8;

  logic [3:0] lpf_hi;

  always_comb begin
    lpf_hi = '0;
    lpf_hi[HI_W-1:0] = lpf_i[LINE_W-1:8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o        <= 1'b0;
      rise_mode_o <= 1'b0;
      fp_o        <= FP_W'(FP_RST);
      bp_o        <= BP_W'(BP_RST);
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: begin
          en_o        <= wdata_i[CTRL_EN_BIT];
          rise_mode_o <= wdata_i[CTRL_RISE_BIT];
        end
        A_FRONT: fp_o <= wdata_i[FP_W-1:0];
        A_BACK:  bp_o <= wdata_i[BP_W-1:0];
        default: ;
      endcase
    end
  end

  // set beats a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_o <= 1'b0;
    else if (upd_set_i) upd_o <= 1'b1;
    else if (rd_i && addr_i == A_LPF_HI) upd_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[CTRL_EN_BIT]   = en_o;
        rdata_o[CTRL_RISE_BIT] = rise_mode_o;
      end
      A_FRONT:  rdata_o = REG_DW'(fp_o);
      A_BACK:   rdata_o = REG_DW'(bp_o);
      A_LPF_LO: rdata_o = lpf_i[7:0];
      A_LPF_HI: begin
        rdata_o[3:0]       = lpf_hi;
        rdata_o[HI_UPD_BIT] = upd_o;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/vfg_vqual.sv
module vfg_vqual #(
  parameter int LINE_W  = 12,
  parameter int WID_MIN = 2,
  parameter int WID_MAX = 7,
  parameter int PER_MIN = 270000,
  parameter int PER_MAX = 1173913
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_i,
  input  logic              vs_i,
  output logic              vs_rise_o,
  output logic              vs_fall_o,
  output logic              accept_o,
  output logic [LINE_W-1:0] line_o,
  output logic [LINE_W-1:0] lpf_o,
  output logic              have_o
);
  localparam int PER_W = $clog2(PER_MAX + 1);
  localparam int WID_W = $clog2(WID_MAX + 2);
  localparam logic [PER_W-1:0]  PER_SAT  = PER_W'(PER_MAX);
  localparam logic [WID_W-1:0]  WID_SAT  = WID_W'(WID_MAX + 1);
  localparam logic [LINE_W-1:0] LINE_SAT = '1;

  logic              vs_q;
  logic [PER_W-1:0]  per_cnt;
  logic              per_ok;
  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] cap_q;
  logic [WID_W-1:0]  width_q;
  logic              width_ok;

  assign vs_rise_o = vs_i & ~vs_q;
  assign vs_fall_o = ~vs_i & vs_q;
  assign width_ok  = (width_q >= WID_W'(WID_MIN)) && (width_q <= WID_W'(WID_MAX));
  assign accept_o  = vs_fall_o & per_ok & width_ok;
  assign line_o    = line_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q    <= 1'b0;
      per_cnt <= PER_SAT;
      per_ok  <= 1'b0;
    end else begin
      vs_q <= vs_i;
      if (vs_rise_o) begin
        per_cnt <= '0;
        // per_cnt holds period-1 here; saturation marks "no prior rise / too long"
        per_ok  <= (per_cnt >= PER_W'(PER_MIN - 1)) && (per_cnt < PER_SAT);
      end else if (per_cnt != PER_SAT) begin
        per_cnt <= per_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_cnt <= '0;
      cap_q    <= '0;
      width_q  <= '0;
    end else if (vs_rise_o) begin
      line_cnt <= '0;
      cap_q    <= line_cnt;
      width_q  <= '0;
    end else if (hs_i) begin
      if (line_cnt != LINE_SAT) line_cnt <= line_cnt + 1'b1;
      if (vs_i && width_q != WID_SAT) width_q <= width_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lpf_o  <= '0;
      have_o <= 1'b0;
    end else if (accept_o) begin
      lpf_o  <= cap_q;
      have_o <= 1'b1;
    end
  end
endmodule

// File: rtl/vfg_field.sv
module vfg_field #(
  parameter int HCNT_W = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_i,
  input  logic vs_rise_i,
  input  logic vs_fall_i,
  input  logic rise_mode_i,
  output logic field_o
);
  localparam logic [HCNT_W-1:0] H_SAT = '1;

  logic [HCNT_W-1:0] h_cnt;
  logic [HCNT_W-1:0] h_len;
  logic              h_seen;
  logic              edge_sel;

  assign edge_sel = rise_mode_i ? vs_rise_i : vs_fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cnt  <= '0;
      h_len  <= '0;
      h_seen <= 1'b0;
    end else if (hs_i) begin
      h_cnt  <= '0;
      h_seen <= 1'b1;
      if (h_seen) h_len <= (h_cnt == H_SAT) ? H_SAT : h_cnt + 1'b1;
    end else if (h_cnt != H_SAT) begin
      h_cnt <= h_cnt + 1'b1;
    end
  end

  // h_cnt is offset-1; second half means offset > len/2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) field_o <= 1'b0;
    else if (edge_sel && h_len != '0) field_o <= (h_cnt >= (h_len >> 1));
  end
endmodule

// File: rtl/vfg_blank.sv
module vfg_blank #(
  parameter int LINE_W = 12,
  parameter int FP_W   = 4,
  parameter int BP_W   = 8
) (
  input  logic              en_i,
  input  logic              have_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] lpf_i,
  input  logic [FP_W-1:0]   fp_i,
  input  logic [BP_W-1:0]   bp_i,
  output logic              vblank_o
);
  logic [LINE_W-1:0] fp_ext;
  logic [LINE_W-1:0] bp_ext;
  logic [LINE_W-1:0] start;
  logic              pre_win;
  logic              post_win;

  assign fp_ext   = LINE_W'(fp_i);
  assign bp_ext   = LINE_W'(bp_i);
  assign start    = (fp_ext > lpf_i) ? '0 : lpf_i - fp_ext;
  assign pre_win  = line_i >= start;
  assign post_win = line_i < bp_ext;
  assign vblank_o = en_i & have_i & (pre_win | post_win);
endmodule

// File: rtl/vblank_field_gen.sv
module vblank_field_gen
  import vfg_pkg::*;
#(
  parameter int LINE_W  = 12,
  parameter int FP_W    = 4,
  parameter int BP_W    = 8,
  parameter int FP_RST  = 4,
  parameter int BP_RST  = 16,
  parameter int WID_MIN = 2,
  parameter int WID_MAX = 7,
  parameter int PER_MIN = 270000,
  parameter int PER_MAX = 1173913,
  parameter int HCNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_i,
  input  logic              vs_i,
  input  logic              reg_we_i,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              vblank_o,
  output logic              field_o
);
  logic              ctrl_en;
  logic              rise_mode;
  logic [FP_W-1:0]   fp;
  logic [BP_W-1:0]   bp;
  logic              upd_flag;
  logic              vs_rise;
  logic              vs_fall;
  logic              accept;
  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] lpf;
  logic              have;

  vfg_regs #(
    .LINE_W(LINE_W), .FP_W(FP_W), .BP_W(BP_W), .FP_RST(FP_RST), .BP_RST(BP_RST)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .rd_i        (reg_rd_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .lpf_i       (lpf),
    .upd_set_i   (accept),
    .en_o        (ctrl_en),
    .rise_mode_o (rise_mode),
    .fp_o        (fp),
    .bp_o        (bp),
    .upd_o       (upd_flag)
  );

  vfg_vqual #(
    .LINE_W(LINE_W), .WID_MIN(WID_MIN), .WID_MAX(WID_MAX),
    .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)
  ) u_vqual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hs_i      (hs_i),
    .vs_i      (vs_i),
    .vs_rise_o (vs_rise),
    .vs_fall_o (vs_fall),
    .accept_o  (accept),
    .line_o    (line_cnt),
    .lpf_o     (lpf),
    .have_o    (have)
  );

  vfg_field #(.HCNT_W(HCNT_W)) u_field (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hs_i        (hs_i),
    .vs_rise_i   (vs_rise),
    .vs_fall_i   (vs_fall),
    .rise_mode_i (rise_mode),
    .field_o     (field_o)
  );

  vfg_blank #(.LINE_W(LINE_W), .FP_W(FP_W), .BP_W(BP_W)) u_blank (
    .en_i     (ctrl_en),
    .have_i   (have),
    .line_i   (line_cnt),
    .lpf_i    (lpf),
    .fp_i     (fp),
    .bp_i     (bp),
    .vblank_o (vblank_o)
  );
endmodule

// File: rtl/vblank_field_gen_chk.sv
module vblank_field_gen_chk #(
  parameter int LINE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vs_i,
  input logic              en_i,
  input logic              have_i,
  input logic              accept_i,
  input logic              upd_i,
  input logic [LINE_W-1:0] lpf_i,
  input logic              vblank_i,
  input logic              field_i
);
  // R2
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !vblank_i);

  // R3
  no_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !have_i |-> !vblank_i);

  // R4
  accept_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> (!vs_i && $past(vs_i)));

  // R5
  lpf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(lpf_i));

  // R6
  upd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> upd_i);

  // R8
  field_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_i == $past(vs_i)) |=> $stable(field_i));
endmodule

bind vblank_field_gen vblank_field_gen_chk #(.LINE_W(LINE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .vs_i     (vs_i),
  .en_i     (ctrl_en),
  .have_i   (have),
  .accept_i (accept),
  .upd_i    (upd_flag),
  .lpf_i    (lpf),
  .vblank_i (vblank_o),
  .field_i  (field_o)
);

// File: tb/test_vblank_field_gen.sv
module test_vblank_field_gen;
  localparam int PMIN = 160;
  localparam int PMAX = 6000;
  localparam int HL   = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hs_i = 1'b0;
  logic       vs_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic       reg_rd_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       vblank_o;
  logic       field_o;

  int checks = 0;
  int fails = 0;
  string g_tag = "";

  // requirement model
  int cyc = 0;
  int m_en = 0, m_mode = 0, m_fp = 4, m_bp = 16;
  int m_line = 0, m_cap = 0, m_lpf = 0, m_have = 0, m_upd = 0;
  int m_width = 0, m_pok = 0, m_rise_seen = 0, m_last_rise = 0;
  int m_hs_seen = 0, m_last_hs = 0, m_hlen = 0, m_field = 0, m_vs = 0;

  always #4 clk_i = ~clk_i;

  vblank_field_gen #(
    .PER_MIN(PMIN), .PER_MAX(PMAX), .HCNT_W(8)
  ) i_vblank_field_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hs_i        (hs_i),
    .vs_i        (vs_i),
    .reg_we_i    (reg_we_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .vblank_o    (vblank_o),
    .field_o     (field_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int exp_vblank();
    int start;
    start = (m_fp > m_lpf) ? 0 : m_lpf - m_fp;
    return (m_en != 0 && m_have != 0 && (m_line >= start || m_line < m_bp)) ? 1 : 0;
  endfunction

  function automatic int exp_rdata(input int a);
    case (a)
      0: return m_mode * 2 + m_en;
      1: return m_fp;
      2: return m_bp;
      3: return m_lpf % 256;
      4: return m_upd * 128 + (m_lpf / 256) % 16;
      default: return 0;
    endcase
  endfunction

  task automatic tick(input bit hs, input bit vs, input bit we, input bit rd,
                      input int a, input int wd);
    int rise, fall, period, acc;
    string t;
    @(negedge clk_i);
    if (g_tag != "") t = g_tag;
    else if (m_en == 0) t = "R2";
    else if (m_have == 0) t = "R3";
    else t = "R7";
    chk({t, " vblank"}, int'(vblank_o), exp_vblank());
    chk((g_tag != "") ? {g_tag, " field"} : "R8 field", int'(field_o), m_field);
    hs_i = hs; vs_i = vs; reg_we_i = we; reg_rd_i = rd;
    reg_addr_i = 3'(a); reg_wdata_i = 8'(wd);
    #1;
    if (rd) begin
      if (g_tag != "") t = g_tag;
      else if (a == 3) t = "R4,R5";
      else if (a == 4) t = "R4,R5,R6";
      else t = "R9";
      chk({t, " rdata"}, int'(reg_rdata_o), exp_rdata(a));
    end
    rise = (vs && m_vs == 0) ? 1 : 0;
    fall = (!vs && m_vs != 0) ? 1 : 0;
    if (((m_mode != 0) ? rise : fall) != 0 && m_hlen > 0)
      m_field = ((cyc - m_last_hs) > m_hlen / 2) ? 1 : 0;
    if (rise != 0) begin
      period = cyc - m_last_rise;
      m_pok = (m_rise_seen != 0 && period >= PMIN && period <= PMAX) ? 1 : 0;
      m_cap = m_line; m_line = 0; m_width = 0;
      m_last_rise = cyc; m_rise_seen = 1;
    end else if (hs) begin
      if (m_line < 4095) m_line++;
      if (vs) m_width++;
    end
    if (hs) begin
      if (m_hs_seen != 0) m_hlen = cyc - m_last_hs;
      m_last_hs = cyc; m_hs_seen = 1;
    end
    acc = (fall != 0 && m_pok != 0 && m_width >= 2 && m_width <= 7) ? 1 : 0;
    if (acc != 0) begin
      m_lpf = m_cap; m_have = 1; m_upd = 1;
    end else if (rd && a == 4) m_upd = 0;
    if (we) begin
      case (a)
        0: begin m_en = wd % 2; m_mode = (wd / 2) % 2; end
        1: m_fp = wd % 16;
        2: m_bp = wd % 256;
        default: ;
      endcase
    end
    m_vs = vs ? 1 : 0;
    cyc++;
  endtask

  task automatic wr(input int a, input int d);
    tick(1'b0, 1'b0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input int a);
    tick(1'b0, 1'b0, 1'b0, 1'b1, a, 0);
  endtask

  task automatic idle_line();
    for (int c = 0; c < HL; c++) tick(c == 0, 1'b0, 1'b0, 1'b0, 0, 0);
  endtask

  // rise in line 0 at offset r, fall in line w at offset f; w < len
  task automatic frame(input int len, input int w, input int r, input int f);
    bit v;
    v = 1'b0;
    for (int j = 0; j < len; j++) begin
      for (int c = 0; c < HL; c++) begin
        if (j == 0 && c == r) v = 1'b1;
        if (j == w && c == f) v = 1'b0;
        tick(c == 0, v, 1'b0, 1'b0, 0, 0);
      end
    end
    rd(3);
    rd(4);
    rd(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    g_tag = "R1";
    for (int a = 0; a < 5; a++) rd(a);
    g_tag = "";

    // R9 register field widths and read-only locations
    wr(0, 8'hFF); rd(0);
    wr(1, 8'hFF); rd(1);
    wr(2, 8'hA5); rd(2);
    wr(3, 8'h55); rd(3);
    wr(4, 8'hFF); rd(4);
    rd(5); rd(6); rd(7);
    wr(0, 0); wr(1, 4); wr(2, 16);

    // R3 enabled, nothing accepted yet
    wr(0, 1);
    idle_line();
    idle_line();
    frame(20, 3, 3, 5);

    // R2 disabled while pulses are accepted
    wr(0, 0);
    frame(20, 3, 3, 5);
    frame(22, 4, 10, 12);
    frame(20, 2, 2, 11);

    // R7/R8 sweep of front and back counts, widths, offsets and edge choice
    k = 0;
    for (int fi = 0; fi < 4; fi++) begin
      for (int bi = 0; bi < 4; bi++) begin
        int fpv, bpv;
        fpv = (fi == 0) ? 0 : (fi == 1) ? 4 : (fi == 2) ? 9 : 15;
        bpv = (bi == 0) ? 0 : (bi == 1) ? 5 : (bi == 2) ? 16 : 30;
        wr(1, fpv);
        wr(2, bpv);
        wr(0, 1 + 2 * (k % 2));
        for (int n = 0; n < 2; n++) begin
          frame(12 + (k * 3) % 18, 2 + k % 6, 1 + (k * 5) % 14, 1 + (k * 7) % 14);
          k++;
        end
      end
    end

    // R4 width limits
    wr(1, 4); wr(2, 8); wr(0, 1);
    for (int w = 1; w <= 8; w++) begin
      frame(20, w, 4, 9);
      frame(21, w, 9, 3);
    end

    // R4 period limits: short then long frames
    frame(8, 3, 5, 5);
    frame(20, 3, 5, 5);
    frame(20, 3, 5, 5);
    wr(0, 3);
    frame(300, 5, 6, 10);
    frame(20, 3, 12, 2);
    frame(25, 3, 12, 2);
    frame(400, 5, 6, 10);
    frame(20, 3, 1, 14);
    frame(20, 3, 14, 1);
    frame(20, 3, 8, 9);

    @(negedge clk_i);
    chk("R7 final vblank", int'(vblank_o), exp_vblank());
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule